// File: doc/BRIEF.md
# SECDED Word Store Merge Unit

This unit sits between a store/read client and a word-organised data array whose 32-bit words are each protected by a single-error-correct, double-error-detect code. Any store that supplies all four bytes of a word is encoded and written straight into the array. A store that supplies fewer bytes cannot be encoded without the rest of the word. Such stores are parked in a one-entry coalescing slot, where later stores to the same word add their bytes. If the slot fills to four bytes, it is written with no array read. Otherwise it is eventually drained by a read-merge-re-encode-write sequence.

Reads are answered one cycle after acceptance with corrected data and two error flags. When a read targets the word held in the slot, the pending bytes are laid over the array word in the response. The merged word is also written back, which empties the slot. The array itself is outside the unit. It is reached through a read port with one cycle of latency and a write port.

Top module: `ecc_store_merge`

## Requirements
- R1: Every array write carries a 39-bit codeword {P, C[5:0], D[31:0]}. Data bit j occupies Hamming position p(j), which is the (j+1)-th integer of 3,5,6,7,9,... (integers from 3 upward that are not powers of two). C[k] is the XOR of the data bits whose position has bit k set. P is the XOR of all other 38 bits.
- R2: A store with all four byte enables set is written to the array in the cycle of its handshake, with no array read.
- R3: A store with fewer than four enables, to an empty slot or to the slot's word, causes no array access. Its bytes are held in the slot.
- R4: Stores to the slot's word accumulate bytes. When the accumulated enables reach all four, the merged word is written in that handshake cycle with no array read.
- R5: A store to a different word while the slot is occupied is stalled (stReady low). The slot is first drained by one array read followed by one write of the corrected array word with the slot bytes laid over it. Only then is the store accepted.
- R6: Asserting flush while idle with an occupied slot drains the slot by the same read-then-write sequence.
- R7: A read accepted in cycle N is answered in cycle N+1 with corrected data. If it targets the slot's word, the response carries the slot bytes over the array word, and that merged word is written back in the same cycle.
- R8: A single-bit error in the read word is corrected. It is flagged with rdSingle on a read response and with an errCorrected pulse on any array check.
- R9: A double-bit error is flagged with rdDouble on a read response and with an errFatal pulse on any array check. No write-back happens in that case, and the slot is discarded.
- R10: After reset both stReady and rdReady are high. Both are low in every cycle that follows an array read until that sequence ends. A valid read takes priority over stores and flush, and holds stReady low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stValid | input | 1 | Store request valid |
| stReady | output | 1 | Store request accepted when high with stValid |
| stAddr | input | ADDR_W | Store word address |
| stData | input | 32 | Store data |
| stBe | input | 4 | Store byte enables |
| flush | input | 1 | Request to drain the coalescing slot |
| rdValid | input | 1 | Read request valid |
| rdReady | output | 1 | Read request accepted when high with rdValid |
| rdAddr | input | ADDR_W | Read word address |
| rdRespValid | output | 1 | Read response valid |
| rdData | output | 32 | Corrected (and slot-merged) read data |
| rdSingle | output | 1 | Response word had a corrected single-bit error |
| rdDouble | output | 1 | Response word had an uncorrectable double-bit error |
| errCorrected | output | 1 | Pulse: single-bit error found on any array check |
| errFatal | output | 1 | Pulse: double-bit error found on any array check |
| arrRdEn | output | 1 | Array read enable |
| arrWrEn | output | 1 | Array write enable |
| arrAddr | output | ADDR_W | Array address for read or write |
| arrWrData | output | 39 | Array write codeword |
| arrRdData | input | 39 | Array read codeword, one cycle after arrRdEn |

## Verification
The bench builds the unit with ADDR_W set to 4, so the array has only sixteen words. Any store to a word other than the slot's word then causes a drain. The bench models those sixteen words itself and flips stored codeword bits in them to place single and double errors. Single errors go into both data and check-bit positions. A double error is also placed under a pending partial store, which makes the suppressed write-back observable.

// File: rtl/ecc_merge_pkg.sv
package ecc_merge_pkg;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int CHK_W  = 6;
  localparam int CW_W   = DATA_W + CHK_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_RESP, S_FLUSH} mergeState_e;
  typedef enum logic [1:0] {ADDR_STORE, ADDR_READ, ADDR_SLOT} addrSel_e;

  typedef struct packed {
    logic     absorb;
    logic     clearSlot;
    logic     capRead;
    addrSel_e addrSel;
    logic     wrFromArr;
    logic     checkEn;
    logic     respValid;
  } ctrlStrb_t;

  // Hamming position of data bit idx: idx-th non-power-of-two from 3 up
  function automatic logic [CHK_W-1:0] posOf(input int idx);
    int n;
    logic [CHK_W-1:0] r;
    n = 0;
    r = '0;
    for (int q = 3; q < (1 << CHK_W); q++) begin
      if ((q & (q - 1)) != 0) begin
        if (n == idx) r = CHK_W'(q);
        n++;
      end
    end
    return r;
  endfunction

  function automatic logic [CHK_W-1:0] eccCheck(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    logic [CHK_W-1:0] p;
    c = '0;
    for (int j = 0; j < DATA_W; j++) begin
      p = posOf(j);
      for (int k = 0; k < CHK_W; k++) if (p[k]) c[k] = c[k] ^ d[j];
    end
    return c;
  endfunction

  function automatic logic [CW_W-1:0] eccEncode(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    c = eccCheck(d);
    return {^{c, d}, c, d};
  endfunction

  function automatic logic [DATA_W-1:0] byteMerge(input logic [DATA_W-1:0] base,
                                                  input logic [DATA_W-1:0] upd,
                                                  input logic [BE_W-1:0] be);
    logic [DATA_W-1:0] r;
    r = base;
    for (int b = 0; b < BE_W; b++) if (be[b]) r[8*b +: 8] = upd[8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/ecc_merge_ctrl.sv
module ecc_merge_ctrl
  import ecc_merge_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      stValid,
  input  logic      rdValid,
  input  logic      flush,
  input  logic      slotValid,
  input  logic      stHit,
  input  logic      storeFull,
  input  logic      respHit,
  input  logic      dblErr,
  output logic      stReady,
  output logic      rdReady,
  output logic      arrRdEn,
  output logic      arrWrEn,
  output ctrlStrb_t strb
);
  mergeState_e state, nextState;
  logic conflict;

  assign conflict = slotValid && (flush || (stValid && !stHit));

  always_comb begin
    strb      = '0;
    stReady   = 1'b0;
    rdReady   = 1'b0;
    arrRdEn   = 1'b0;
    arrWrEn   = 1'b0;
    nextState = state;
    unique case (state)
      S_IDLE: begin
        rdReady = 1'b1;
        if (rdValid) begin
          arrRdEn      = 1'b1;
          strb.addrSel = ADDR_READ;
          strb.capRead = 1'b1;
          nextState    = S_RESP;
        end else if (conflict) begin
          arrRdEn      = 1'b1;
          strb.addrSel = ADDR_SLOT;
          nextState    = S_FLUSH;
        end else begin
          stReady = 1'b1;
          if (stValid) begin
            if (storeFull) begin
              arrWrEn        = 1'b1;
              strb.addrSel   = ADDR_STORE;
              strb.clearSlot = 1'b1;
            end else begin
              strb.absorb = 1'b1;
            end
          end
        end
      end
      S_RESP: begin
        strb.respValid = 1'b1;
        strb.checkEn   = 1'b1;
        if (respHit) begin
          strb.clearSlot = 1'b1;
          strb.addrSel   = ADDR_SLOT;
          strb.wrFromArr = 1'b1;
          arrWrEn        = !dblErr;
        end
        nextState = S_IDLE;
      end
      default: begin
        strb.checkEn   = 1'b1;
        strb.clearSlot = 1'b1;
        strb.addrSel   = ADDR_SLOT;
        strb.wrFromArr = 1'b1;
        arrWrEn        = !dblErr;
        nextState      = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/ecc_merge_dp.sv
module ecc_merge_dp
  import ecc_merge_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic [BE_W-1:0]   stBe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [CW_W-1:0]   arrRdData,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [CW_W-1:0]   arrWrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdSingle,
  output logic              rdDouble,
  output logic              rdRespValid,
  output logic              errCorrected,
  output logic              errFatal,
  output logic              slotValid,
  output logic              stHit,
  output logic              storeFull,
  output logic              respHit,
  output logic              dblErr
);
  logic              slotValidQ;
  logic [ADDR_W-1:0] slotAddrQ, rdAddrQ;
  logic [DATA_W-1:0] slotDataQ;
  logic [BE_W-1:0]   slotBeQ;

  logic [DATA_W-1:0] storeMerged, corrData, arrMerged, wrWord;
  logic [BE_W-1:0]   storeBe;
  logic [CHK_W-1:0]  syndrome;
  logic              overall, sglErr;

  assign stHit       = slotValidQ && (stAddr == slotAddrQ);
  assign respHit     = slotValidQ && (slotAddrQ == rdAddrQ);
  assign storeMerged = stHit ? byteMerge(slotDataQ, stData, stBe) : stData;
  assign storeBe     = (stHit ? slotBeQ : '0) | stBe;
  assign storeFull   = &storeBe;
  assign slotValid   = slotValidQ;

  // Decode the word returned by the array
  always_comb begin
    syndrome = arrRdData[DATA_W +: CHK_W] ^ eccCheck(arrRdData[DATA_W-1:0]);
    overall  = ^arrRdData;
    corrData = arrRdData[DATA_W-1:0];
    for (int j = 0; j < DATA_W; j++)
      if (overall && (syndrome == posOf(j))) corrData[j] = ~arrRdData[j];
  end

  assign sglErr    = overall;
  assign dblErr    = !overall && (syndrome != '0);
  assign arrMerged = byteMerge(corrData, slotDataQ, slotBeQ);

  always_comb begin
    unique case (strb.addrSel)
      ADDR_READ: arrAddr = rdAddr;
      ADDR_SLOT: arrAddr = slotAddrQ;
      default:   arrAddr = stAddr;
    endcase
  end

  assign wrWord       = strb.wrFromArr ? arrMerged : storeMerged;
  assign arrWrData    = eccEncode(wrWord);
  assign rdRespValid  = strb.respValid;
  assign rdData       = respHit ? arrMerged : corrData;
  assign rdSingle     = strb.respValid && sglErr;
  assign rdDouble     = strb.respValid && dblErr;
  assign errCorrected = strb.checkEn && sglErr;
  assign errFatal     = strb.checkEn && dblErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValidQ <= 1'b0;
      slotAddrQ  <= '0;
      slotDataQ  <= '0;
      slotBeQ    <= '0;
      rdAddrQ    <= '0;
    end else begin
      if (strb.clearSlot) begin
        slotValidQ <= 1'b0;
        slotBeQ    <= '0;
      end else if (strb.absorb) begin
        slotValidQ <= 1'b1;
        slotAddrQ  <= stAddr;
        slotDataQ  <= storeMerged;
        slotBeQ    <= storeBe;
      end
      if (strb.capRead) rdAddrQ <= rdAddr;
    end
  end
endmodule

// File: rtl/ecc_store_merge.sv
module ecc_store_merge
  import ecc_merge_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stValid,
  output logic              stReady,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [31:0]       stData,
  input  logic [3:0]        stBe,
  input  logic              flush,
  input  logic              rdValid,
  output logic              rdReady,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              rdRespValid,
  output logic [31:0]       rdData,
  output logic              rdSingle,
  output logic              rdDouble,
  output logic              errCorrected,
  output logic              errFatal,
  output logic              arrRdEn,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [38:0]       arrWrData,
  input  logic [38:0]       arrRdData
);
  ctrlStrb_t strb;
  logic slotValid, stHit, storeFull, respHit, dblErr;

  ecc_merge_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .stValid(stValid), .rdValid(rdValid), .flush(flush),
    .slotValid(slotValid), .stHit(stHit), .storeFull(storeFull), .respHit(respHit),
    .dblErr(dblErr), .stReady(stReady), .rdReady(rdReady), .arrRdEn(arrRdEn),
    .arrWrEn(arrWrEn), .strb(strb)
  );

  ecc_merge_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .stAddr(stAddr), .stData(stData), .stBe(stBe),
    .rdAddr(rdAddr), .arrRdData(arrRdData), .arrAddr(arrAddr), .arrWrData(arrWrData),
    .rdData(rdData), .rdSingle(rdSingle), .rdDouble(rdDouble), .rdRespValid(rdRespValid),
    .errCorrected(errCorrected), .errFatal(errFatal), .slotValid(slotValid),
    .stHit(stHit), .storeFull(storeFull), .respHit(respHit), .dblErr(dblErr)
  );
endmodule

// File: rtl/ecc_store_merge_chk.sv
module ecc_store_merge_chk (
  input logic       clk,
  input logic       rstN,
  input logic       stValid,
  input logic       stReady,
  input logic [3:0] stBe,
  input logic       rdReady,
  input logic       rdRespValid,
  input logic       errCorrected,
  input logic       errFatal,
  input logic       arrRdEn,
  input logic       arrWrEn
);
  AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(arrRdEn && arrWrEn)); // R2
  AST_FULL_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (stValid && stReady && stBe == 4'hF) |-> (arrWrEn && !arrRdEn)); // R2
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    arrRdEn |=> (!stReady && !rdReady)); // R10
  AST_RESP_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    rdRespValid |-> $past(arrRdEn)); // R7
  AST_FATAL_NO_WB: assert property (@(posedge clk) disable iff (!rstN)
    errFatal |-> !arrWrEn); // R9
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(errCorrected && errFatal)); // R8
endmodule

bind ecc_store_merge ecc_store_merge_chk chk_i (
  .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady), .stBe(stBe),
  .rdReady(rdReady), .rdRespValid(rdRespValid), .errCorrected(errCorrected),
  .errFatal(errFatal), .arrRdEn(arrRdEn), .arrWrEn(arrWrEn)
);

// File: tb/ecc_store_merge_tb_top.sv
module ecc_store_merge_tb_top;
  localparam int AW = 4;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stValid = 1'b0, flush = 1'b0, rdValid = 1'b0;
  logic [AW-1:0] stAddr = '0, rdAddr = '0;
  logic [31:0] stData = '0;
  logic [3:0] stBe = '0;
  logic stReady, rdReady, rdRespValid, rdSingle, rdDouble, errCorrected, errFatal;
  logic arrRdEn, arrWrEn;
  logic [AW-1:0] arrAddr;
  logic [38:0] arrWrData;
  logic [38:0] arrRdData = '0;

  always #5 clk = ~clk;

  ecc_store_merge #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady), .stAddr(stAddr),
    .stData(stData), .stBe(stBe), .flush(flush), .rdValid(rdValid), .rdReady(rdReady),
    .rdAddr(rdAddr), .rdRespValid(rdRespValid), .rdData(rdData), .rdSingle(rdSingle),
    .rdDouble(rdDouble), .errCorrected(errCorrected), .errFatal(errFatal),
    .arrRdEn(arrRdEn), .arrWrEn(arrWrEn), .arrAddr(arrAddr), .arrWrData(arrWrData),
    .arrRdData(arrRdData)
  );
  logic [31:0] rdData;

  int vectors = 0, fails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent codeword builder from the R1 layout
  function automatic logic [38:0] tbEnc(input logic [31:0] d);
    logic [5:0] c;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p < 64; p++) begin
      if (j < 32 && (p & (p - 1)) != 0 && p > 2) begin
        for (int k = 0; k < 6; k++) if (((p >> k) & 1) == 1) c[k] ^= d[j];
        j++;
      end
    end
    return {^{c, d}, c, d};
  endfunction

  function automatic logic [31:0] tbMerge(input logic [31:0] b, input logic [31:0] u,
                                          input logic [3:0] be);
    logic [31:0] r;
    r = b;
    for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = u[8*i +: 8];
    return r;
  endfunction

  // Array model with bit-flip injection
  logic [38:0] mem [WORDS];
  logic injGo = 1'b0;
  logic [AW-1:0] injAddr = '0;
  logic [38:0] injMask = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= tbEnc(32'h1111_1111 * i);
    end else begin
      if (arrWrEn) mem[arrAddr] <= arrWrData;
      else if (injGo) mem[injAddr] <= mem[injAddr] ^ injMask;
      if (arrRdEn) arrRdData <= mem[arrAddr];
    end
  end

  // Behavioural reference: logical word contents and injected error counts
  logic [31:0] golden [WORDS];
  int errCnt [WORDS];
  logic [31:0] expData [$];
  int expErr [$];
  int rdCnt = 0, wrCnt = 0, fatalCnt = 0, corrCnt = 0, stallCnt = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) begin
        golden[i] = 32'h1111_1111 * i;
        errCnt[i] = 0;
      end
    end else begin
      if (injGo) errCnt[injAddr] += $countones(injMask);
      if (rdRespValid) begin
        if (expData.size() == 0) check(0, "R7 unexpected response", 1, 0);
        else begin
          logic [31:0] ed;
          int ee;
          ed = expData.pop_front();
          ee = expErr.pop_front();
          if (ee < 2) check(rdData == ed, "R7 read data", rdData, ed);
          check(rdSingle == (ee == 1), "R8 rdSingle", rdSingle, ee == 1);
          check(errCorrected == (ee == 1), "R8 errCorrected", errCorrected, ee == 1);
          check(rdDouble == (ee >= 2), "R9 rdDouble", rdDouble, ee >= 2);
        end
      end
      if (arrRdEn) rdCnt++;
      if (arrWrEn) wrCnt++;
      if (errFatal) fatalCnt++;
      if (errCorrected) corrCnt++;
      if (stValid && !stReady) stallCnt++;
      if (stValid && stReady) golden[stAddr] = tbMerge(golden[stAddr], stData, stBe);
      if (arrWrEn) begin
        check(arrWrData == tbEnc(golden[arrAddr]), "R1 write codeword",
              arrWrData, tbEnc(golden[arrAddr]));
        errCnt[arrAddr] = 0;
      end
      if (rdValid && rdReady) begin
        expData.push_back(golden[rdAddr]);
        expErr.push_back(errCnt[rdAddr]);
      end
    end
  end

  task automatic doStore(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
    @(posedge clk); #1;
    stValid = 1'b1; stAddr = a; stData = d; stBe = be;
    do @(negedge clk); while (!stReady);
    @(posedge clk); #1;
    stValid = 1'b0;
  endtask

  task automatic doRead(input logic [AW-1:0] a);
    @(posedge clk); #1;
    rdValid = 1'b1; rdAddr = a;
    do @(negedge clk); while (!rdReady);
    @(posedge clk); #1;
    rdValid = 1'b0;
  endtask

  task automatic doFlush();
    @(posedge clk); #1;
    flush = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0;
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [38:0] m);
    @(posedge clk); #1;
    injGo = 1'b1; injAddr = a; injMask = m;
    @(posedge clk); #1;
    injGo = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  int r0, w0, f0, c0, s0;
  task automatic mark();
    r0 = rdCnt; w0 = wrCnt; f0 = fatalCnt; c0 = corrCnt; s0 = stallCnt;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(stReady && rdReady, "R10 readies after reset", {stReady, rdReady}, 2'b11);
    check(!rdRespValid && !arrWrEn && !arrRdEn, "R10 quiet after reset",
          {rdRespValid, arrWrEn, arrRdEn}, 0);

    mark(); doStore(4'd1, 32'hA5A5_5A5A, 4'hF); settle();
    check(rdCnt - r0 == 0, "R2 full store no read", rdCnt - r0, 0);
    check(wrCnt - w0 == 1, "R2 full store one write", wrCnt - w0, 1);

    mark(); doStore(4'd2, 32'h0000_00C1, 4'b0001); settle();
    check(rdCnt - r0 == 0 && wrCnt - w0 == 0, "R3 partial held", {rdCnt - r0, wrCnt - w0}, 0);

    mark();
    doStore(4'd2, 32'h0000_C200, 4'b0010);
    doStore(4'd2, 32'h00C3_0000, 4'b0100);
    doStore(4'd2, 32'hC400_0000, 4'b1000); settle();
    check(rdCnt - r0 == 0, "R4 coalesced no read", rdCnt - r0, 0);
    check(wrCnt - w0 == 1, "R4 coalesced one write", wrCnt - w0, 1);

    doStore(4'd3, 32'h0000_BEEF, 4'b0011);
    mark(); doStore(4'd4, 32'h0000_0077, 4'b0001); settle();
    check(rdCnt - r0 == 1 && wrCnt - w0 == 1, "R5 conflict drain",
          {rdCnt - r0, wrCnt - w0}, {32'd1, 32'd1});
    check(stallCnt - s0 >= 1, "R5 store stalled", stallCnt - s0, 1);

    mark(); doFlush(); settle();
    check(rdCnt - r0 == 1 && wrCnt - w0 == 1, "R6 flush drain",
          {rdCnt - r0, wrCnt - w0}, {32'd1, 32'd1});

    doRead(4'd1); settle();
    doStore(4'd5, 32'hDEAD_0000, 4'b1100);
    mark(); doRead(4'd5); settle();
    check(wrCnt - w0 == 1, "R7 slot hit write-back", wrCnt - w0, 1);

    inject(4'd1, 39'h1 << 7); doRead(4'd1); settle();
    inject(4'd3, 39'h1 << 35); doRead(4'd3); settle();

    inject(4'd6, 39'h3); doStore(4'd6, 32'h0000_0012, 4'b0001);
    mark(); doFlush(); settle();
    check(fatalCnt - f0 == 1, "R9 fatal on drain", fatalCnt - f0, 1);
    check(wrCnt - w0 == 0, "R9 no write-back", wrCnt - w0, 0);
    doRead(4'd6); settle();
    doStore(4'd6, 32'h6666_6666, 4'hF); settle();
    doRead(4'd6); settle();

    inject(4'd7, 39'h1 << 20); doStore(4'd7, 32'h0000_0034, 4'b0001);
    mark(); doFlush(); settle();
    check(corrCnt - c0 == 1 && wrCnt - w0 == 1, "R8 corrected drain",
          {corrCnt - c0, wrCnt - w0}, {32'd1, 32'd1});
    doRead(4'd7); settle();

    doStore(4'd8, 32'h0000_5500, 4'b0010);
    mark(); doStore(4'd9, 32'h9999_0000, 4'hF); settle();
    check(rdCnt - r0 == 1 && wrCnt - w0 == 2, "R5 full store after drain",
          {rdCnt - r0, wrCnt - w0}, {32'd1, 32'd2});
    doRead(4'd8); doRead(4'd9); doRead(4'd2); doRead(4'd4); settle();
    check(expData.size() == 0, "R7 all responses seen", expData.size(), 0);
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finishRun();
  end
endmodule